// File: doc/BRIEF.md
# Serial Port Register and Interrupt Front End

This block is the register-side face of a serial port. A 32-bit word bus reaches four registers: a control word, a receive data port, a transmit data port and a status word. The control word holds the frame format, the flow-control and loopback choices, the global enable, and separate interrupt and DMA enables for each direction. It drives these settings straight to the serial engines.

Bus writes to the transmit data port go into a transmit FIFO. The serialiser drains that FIFO through a valid/ready pair. The deserialiser pushes bytes into a receive FIFO, and bus reads of the receive data port pop them. Both FIFOs are parameterised synchronous queues inside the block.

The status word combines live FIFO flags, the modem lines, a fill-level field and five sticky event bits. The event bits are cleared by writing one to them. Two of the sticky bits are the pending bits, and together they drive a single level-sensitive interrupt.

Top module: `sio_csr`

## Requirements
- R1: After reset the control word reads 0. A control write stores bits 1:0, 2, 6:4, 12, 14, 15 and 16 to 20, and a read returns exactly those bits, with every other bit zero.
- R2: The frame outputs follow the control word: data length = bits 1:0 (0 = 5 bits … 3 = 8 bits), two stop bits = bit 2, parity = bits 6:4 (0 none, 4 odd, 5 mark, 6 even, 7 space), loopback = bit 20, engine enable = bit 15.
- R3: A write to offset 0x008 appends wdata[7:0] to the TX FIFO. Entries leave in write order on `tx_data_o`, one per cycle in which `tx_valid_o` and `tx_ready_i` are both high.
- R4: A write to 0x008 while the TX FIFO is full is dropped and sets status bit 3.
- R5: A read of 0x004 pops one RX entry and returns it in bits 7:0, with bits 31:8 zero. When the RX FIFO is empty the read returns the last popped byte and the level stays at zero.
- R6: An RX push while the RX FIFO is full is discarded and sets status bit 2. A push with `rx_err_i` high sets status bit 4.
- R7: Writing 1 to any of status bits 4:0 at offset 0x00C clears that bit. An event or pending condition in the same cycle wins over the clear.
- R8: Status bit 0 becomes set one cycle after the RX FIFO is non-empty while control bit 18 is set. Status bit 1 becomes set one cycle after the TX FIFO is not full while control bit 19 is set. `irq_o` is high while either bit is set.
- R9: Status bits: 5 = RX FIFO empty, 6 = TX FIFO full, 7 = `cts_i`, 8 = `rts_o`, 10 = TX FIFO empty, 17 = `tx_busy_i`. Bits 16:11 hold the TX FIFO level when control bit 14 is set and the RX FIFO level when it is clear.
- R10: While control bit 15 is low, both FIFOs are emptied on the next edge, `tx_valid_o` is low, and transmit writes and receive pushes have no effect.
- R11: With control bit 12 set, `tx_valid_o` requires `cts_i` high, and `rts_o` is low while the RX FIFO is full. With bit 12 clear, `rts_o` is high.
- R12: `dma_rx_req_o` = control bit 16 AND RX FIFO non-empty. `dma_tx_req_o` = control bit 17 AND bit 15 AND TX FIFO not full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | ADDR_W | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the same cycle as the request |
| tx_data_o | output | 8 | Head byte of the TX FIFO |
| tx_valid_o | output | 1 | A TX byte is offered to the serialiser |
| tx_ready_i | input | 1 | The serialiser takes the offered byte |
| tx_busy_i | input | 1 | The serialiser is shifting a frame |
| rx_data_i | input | 8 | Byte from the deserialiser |
| rx_valid_i | input | 1 | Push strobe for `rx_data_i` |
| rx_err_i | input | 1 | The pushed byte had a parity or framing error |
| cts_i | input | 1 | Clear-to-send line level |
| rts_o | output | 1 | Request-to-send line level |
| data_len_o | output | 2 | Data length code |
| two_stop_o | output | 1 | Two stop bits selected |
| parity_o | output | 3 | Parity mode code |
| loopback_o | output | 1 | Internal loopback selected |
| engine_en_o | output | 1 | Serial engines enabled |
| dma_rx_req_o | output | 1 | RX DMA request |
| dma_tx_req_o | output | 1 | TX DMA request |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions assume that `rx_valid_i` is a one-cycle strobe. They also assume that the bus never makes a transmit write and a receive read at once, because a request names only one address. The stimulus therefore drives each bus access and each receive push in a task of its own, and each task drops its strobe after one cycle. The fill and drain patterns stay within the FIFO depths except in the directed overflow cases. The random mix consults a bench model of both queues before it pushes or pops.

// File: rtl/sio_csr_pkg.sv
package sio_csr_pkg;

  localparam int unsigned NUM_EV = 5;
  localparam int unsigned EV_RXP = 0;
  localparam int unsigned EV_TXP = 1;
  localparam int unsigned EV_OVR = 2;
  localparam int unsigned EV_TXE = 3;
  localparam int unsigned EV_RXE = 4;
  localparam int unsigned LVL_W  = 6;

  typedef struct packed {
    logic       loop;
    logic       tx_ie;
    logic       rx_ie;
    logic       tx_de;
    logic       rx_de;
    logic       en;
    logic       lvl_tx;
    logic       flow;
    logic [2:0] parity;
    logic       two_stop;
    logic [1:0] dlen;
  } ctl_t;

  function automatic ctl_t ctl_unpack(input logic [31:0] w);
    ctl_t c;
    c.dlen     = w[1:0];
    c.two_stop = w[2];
    c.parity   = w[6:4];
    c.flow     = w[12];
    c.lvl_tx   = w[14];
    c.en       = w[15];
    c.rx_de    = w[16];
    c.tx_de    = w[17];
    c.rx_ie    = w[18];
    c.tx_ie    = w[19];
    c.loop     = w[20];
    return c;
  endfunction

  function automatic logic [31:0] ctl_pack(input ctl_t c);
    logic [31:0] w;
    w        = '0;
    w[1:0]   = c.dlen;
    w[2]     = c.two_stop;
    w[6:4]   = c.parity;
    w[12]    = c.flow;
    w[14]    = c.lvl_tx;
    w[15]    = c.en;
    w[16]    = c.rx_de;
    w[17]    = c.tx_de;
    w[18]    = c.rx_ie;
    w[19]    = c.tx_ie;
    w[20]    = c.loop;
    return w;
  endfunction

endpackage

// File: rtl/sio_fifo.sv
module sio_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [CW-1:0]    level_o
);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PW-1:0]    wr_q, rd_q;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign level_o = cnt_q;
  assign data_o  = mem_q[rd_q];
  assign do_push = push_i & ~full_o & ~clr_i;
  assign do_pop  = pop_i & ~empty_o & ~clr_i;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

endmodule

// File: rtl/sio_sticky.sv
module sio_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= set_i | (q_o & ~clr_i);
  end

endmodule

// File: rtl/sio_csr.sv
module sio_csr
  import sio_csr_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned TX_DEPTH = 16,
  parameter int unsigned RX_DEPTH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  input  logic              tx_busy_i,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_valid_i,
  input  logic              rx_err_i,
  input  logic              cts_i,
  output logic              rts_o,
  output logic [1:0]        data_len_o,
  output logic              two_stop_o,
  output logic [2:0]        parity_o,
  output logic              loopback_o,
  output logic              engine_en_o,
  output logic              dma_rx_req_o,
  output logic              dma_tx_req_o,
  output logic              irq_o
);

  localparam int unsigned TXLW = $clog2(TX_DEPTH + 1);
  localparam int unsigned RXLW = $clog2(RX_DEPTH + 1);

  ctl_t              ctl_q;
  logic              sel_ctl, sel_rxd, sel_txd, sel_sts;
  logic              en_w, rx_ie_w;
  logic              tx_push, tx_pop, tx_empty, tx_full;
  logic              rx_push, rx_pop, rx_empty, rx_full;
  logic [7:0]        rx_head, last_rx_q, rx_rd;
  logic [TXLW-1:0]   tx_lvl;
  logic [RXLW-1:0]   rx_lvl;
  logic [LVL_W-1:0]  lvl_w;
  logic [NUM_EV-1:0] ev_set, ev_clr, ev_q;
  logic [31:0]       sts_w;

  assign sel_ctl = req_i & (addr_i == ADDR_W'('h000));
  assign sel_rxd = req_i & (addr_i == ADDR_W'('h004));
  assign sel_txd = req_i & (addr_i == ADDR_W'('h008));
  assign sel_sts = req_i & (addr_i == ADDR_W'('h00C));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               ctl_q <= '0;
    else if (sel_ctl && we_i)  ctl_q <= ctl_unpack(wdata_i);
  end

  assign en_w    = ctl_q.en;
  assign rx_ie_w = ctl_q.rx_ie;

  assign tx_push    = sel_txd & we_i & en_w;
  assign tx_valid_o = en_w & ~tx_empty & (~ctl_q.flow | cts_i);
  assign tx_pop     = tx_valid_o & tx_ready_i;

  sio_fifo #(.WIDTH(8), .DEPTH(TX_DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni, .clr_i(~en_w),
    .push_i(tx_push), .data_i(wdata_i[7:0]), .pop_i(tx_pop),
    .data_o(tx_data_o), .empty_o(tx_empty), .full_o(tx_full), .level_o(tx_lvl)
  );

  assign rx_push = rx_valid_i & en_w;
  assign rx_pop  = sel_rxd & ~we_i & en_w;

  sio_fifo #(.WIDTH(8), .DEPTH(RX_DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni, .clr_i(~en_w),
    .push_i(rx_push), .data_i(rx_data_i), .pop_i(rx_pop),
    .data_o(rx_head), .empty_o(rx_empty), .full_o(rx_full), .level_o(rx_lvl)
  );

  // an empty read repeats the last byte popped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  last_rx_q <= '0;
    else if (rx_pop && !rx_empty) last_rx_q <= rx_head;
  end
  assign rx_rd = rx_empty ? last_rx_q : rx_head;

  always_comb begin
    ev_set         = '0;
    ev_set[EV_RXP] = ~rx_empty & ctl_q.rx_ie;
    ev_set[EV_TXP] = ~tx_full & ctl_q.tx_ie;
    ev_set[EV_OVR] = rx_push & rx_full;
    ev_set[EV_TXE] = tx_push & tx_full;
    ev_set[EV_RXE] = rx_push & rx_err_i;
  end

  for (genvar g = 0; g < NUM_EV; g++) begin : g_ev
    assign ev_clr[g] = sel_sts & we_i & wdata_i[g];
    sio_sticky u_ev (
      .clk_i, .rst_ni, .set_i(ev_set[g]), .clr_i(ev_clr[g]), .q_o(ev_q[g])
    );
  end

  assign rts_o = ~(ctl_q.flow & rx_full);
  assign lvl_w = ctl_q.lvl_tx ? LVL_W'(tx_lvl) : LVL_W'(rx_lvl);

  always_comb begin
    sts_w                    = '0;
    sts_w[NUM_EV-1:0]        = ev_q;
    sts_w[5]                 = rx_empty;
    sts_w[6]                 = tx_full;
    sts_w[7]                 = cts_i;
    sts_w[8]                 = rts_o;
    sts_w[10]                = tx_empty;
    sts_w[11 +: LVL_W]       = lvl_w;
    sts_w[17]                = tx_busy_i;
  end

  always_comb begin
    rdata_o = '0;
    if (sel_ctl)      rdata_o = ctl_pack(ctl_q);
    else if (sel_rxd) rdata_o = {24'b0, rx_rd};
    else if (sel_sts) rdata_o = sts_w;
  end

  assign irq_o        = ev_q[EV_RXP] | ev_q[EV_TXP];
  assign dma_rx_req_o = ctl_q.rx_de & ~rx_empty;
  assign dma_tx_req_o = ctl_q.tx_de & en_w & ~tx_full;
  assign data_len_o   = ctl_q.dlen;
  assign two_stop_o   = ctl_q.two_stop;
  assign parity_o     = ctl_q.parity;
  assign loopback_o   = ctl_q.loop;
  assign engine_en_o  = en_w;

endmodule

// File: rtl/sio_csr_chk.sv
module sio_csr_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        tx_push,
  input logic        rx_push,
  input logic        rx_full,
  input logic        rx_pop,
  input logic        en_w,
  input logic        rx_ie_w,
  input logic [31:0] sts_w
);

  a_r4_full_write_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_push && sts_w[6]) |=> sts_w[3]);

  a_r6_overrun_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push && rx_full) |=> sts_w[2]);

  a_r8_rx_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sts_w[5] && rx_ie_w) |=> sts_w[0]);

  a_r10_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_w |=> (sts_w[5] && sts_w[10]));

  a_r5_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_pop && sts_w[5] && !rx_push) |=> sts_w[5]);

endmodule

bind sio_csr sio_csr_chk u_sio_csr_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tx_push (tx_push),
  .rx_push (rx_push),
  .rx_full (rx_full),
  .rx_pop  (rx_pop),
  .en_w    (en_w),
  .rx_ie_w (rx_ie_w),
  .sts_w   (sts_w)
);

// File: tb/test_sio_csr.sv
module test_sio_csr;

  localparam int TXD = 16;
  localparam int RXD = 16;
  localparam logic [11:0] A_CTL = 12'h000, A_RXD = 12'h004, A_TXD = 12'h008, A_STS = 12'h00C;
  localparam logic [31:0] CTL_MASK = 32'h001F_D077;
  localparam logic [31:0] EN = 32'h8000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        req = 0, we = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [7:0]  tx_data, rx_data = '0;
  logic        tx_valid, tx_ready = 0, tx_busy = 0, rx_valid = 0, rx_err = 0, cts = 0, rts;
  logic [1:0]  data_len;
  logic        two_stop, loopback, engine_en, dma_rx, dma_tx, irq;
  logic [2:0]  parity;

  sio_csr i_sio_csr (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tx_data_o(tx_data), .tx_valid_o(tx_valid),
    .tx_ready_i(tx_ready), .tx_busy_i(tx_busy), .rx_data_i(rx_data),
    .rx_valid_i(rx_valid), .rx_err_i(rx_err), .cts_i(cts), .rts_o(rts),
    .data_len_o(data_len), .two_stop_o(two_stop), .parity_o(parity),
    .loopback_o(loopback), .engine_en_o(engine_en), .dma_rx_req_o(dma_rx),
    .dma_tx_req_o(dma_tx), .irq_o(irq)
  );

  int n_run = 0, n_fail = 0;
  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  logic [7:0] last_rx = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    #2 d = rdata;
    @(negedge clk); req = 0;
  endtask

  task automatic rx_put(input logic [7:0] b, input logic e);
    @(negedge clk); rx_valid = 1; rx_data = b; rx_err = e;
    @(negedge clk); rx_valid = 0; rx_err = 0;
  endtask

  task automatic tx_take(output logic [7:0] b, output logic v);
    @(negedge clk); v = tx_valid; b = tx_data; tx_ready = 1;
    @(negedge clk); tx_ready = 0;
  endtask

  function automatic logic [5:0] lvl_of(input logic [31:0] s);
    return s[16:11];
  endfunction

  initial begin
    logic [31:0] d, v;
    logic [7:0]  b;
    logic        vb;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset values
    rd(A_CTL, d); chk("R1 reset ctl", d, 0);
    rd(A_STS, d); chk("R9 reset status", d, 32'h0000_0520);
    chk("R8 reset irq", irq, 0);

    // R1 R2 control field mapping
    wr(A_CTL, 32'hFFFF_FFFF);
    rd(A_CTL, d); chk("R1 all-ones readback", d, CTL_MASK);
    chk("R2 dlen", data_len, 3); chk("R2 parity", parity, 7);
    chk("R2 stop", two_stop, 1); chk("R2 loop", loopback, 1); chk("R2 en", engine_en, 1);
    for (int i = 0; i < 6; i++) begin
      v = $urandom;
      wr(A_CTL, v);
      rd(A_CTL, d); chk("R1 random readback", d, v & CTL_MASK);
      chk("R2 random fields", {data_len, two_stop, parity, loopback, engine_en},
          {v[1:0], v[2], v[6:4], v[20], v[15]});
    end
    wr(A_CTL, 0); wr(A_STS, 32'h1F);
    rd(A_STS, d); chk("R7 w1c all events", d, 32'h0000_0520);

    // R3 TX ordering, R9 TX level
    wr(A_CTL, EN | 32'h4000);
    for (int i = 0; i < 5; i++) begin b = 8'($urandom); txq.push_back(b); wr(A_TXD, {24'hABCDEF, b}); end
    rd(A_STS, d); chk("R9 tx level", lvl_of(d), 5); chk("R9 tx empty flag", d[10], 0);
    while (txq.size() > 0) begin
      tx_take(b, vb); chk("R3 tx valid", vb, 1); chk("R3 tx order", b, txq.pop_front());
    end
    chk("R3 tx drained", tx_valid, 0);

    // R4 overflow
    for (int i = 0; i < TXD + 1; i++) begin b = 8'($urandom); if (i < TXD) txq.push_back(b); wr(A_TXD, b); end
    rd(A_STS, d);
    chk("R4 full flag", d[6], 1); chk("R4 error flag", d[3], 1); chk("R9 tx level full", lvl_of(d), TXD);
    while (txq.size() > 0) begin tx_take(b, vb); chk("R4 kept data", b, txq.pop_front()); end
    wr(A_STS, 32'h8); rd(A_STS, d); chk("R7 clear tx error", d[3], 0);

    // R5 RX pop and empty read
    wr(A_CTL, EN);
    for (int i = 0; i < 4; i++) begin b = 8'($urandom); rxq.push_back(b); rx_put(b, 0); end
    rd(A_STS, d); chk("R9 rx level", lvl_of(d), 4);
    while (rxq.size() > 0) begin last_rx = rxq.pop_front(); rd(A_RXD, d); chk("R5 rx data", d, {24'b0, last_rx}); end
    rd(A_RXD, d); chk("R5 empty read", d, {24'b0, last_rx});
    rd(A_STS, d); chk("R5 no underflow", {d[5], lvl_of(d)}, {1'b1, 6'd0});

    // R6 overrun and receive error
    for (int i = 0; i < RXD + 1; i++) begin b = 8'($urandom); if (i < RXD) rxq.push_back(b); rx_put(b, 0); end
    rd(A_STS, d); chk("R6 overrun", d[2], 1);
    while (rxq.size() > 0) begin last_rx = rxq.pop_front(); rd(A_RXD, d); chk("R6 kept data", d[7:0], last_rx); end
    rx_put(8'h5A, 1);
    rd(A_STS, d); chk("R6 rx error", d[4], 1);
    rd(A_RXD, d); last_rx = 8'h5A;
    wr(A_STS, 32'h14); rd(A_STS, d); chk("R7 clear errors", d[4:0], 0);

    // R8 interrupts
    wr(A_CTL, EN | (32'h1 << 18));
    chk("R8 idle irq", irq, 0);
    rx_put(8'h33, 0); @(negedge clk);
    chk("R8 rx irq", irq, 1);
    rd(A_RXD, d); last_rx = 8'h33;
    chk("R8 pending sticky", irq, 1);
    wr(A_STS, 32'h1); chk("R8 irq cleared", irq, 0);
    wr(A_CTL, EN | (32'h1 << 19)); @(negedge clk);
    chk("R8 tx irq", irq, 1);
    rd(A_STS, d); chk("R8 tx pending bit", d[1], 1);
    wr(A_CTL, EN); wr(A_STS, 32'h3); chk("R7 irq off", irq, 0);

    // R11 flow control, R9 line bits
    wr(A_CTL, EN | 32'h1000);
    cts = 0; wr(A_TXD, 8'h77); @(negedge clk);
    chk("R11 cts blocks", tx_valid, 0); chk("R11 rts ready", rts, 1);
    cts = 1; tx_busy = 1; #1 chk("R11 cts allows", tx_valid, 1);
    rd(A_STS, d); chk("R9 cts and busy bits", {d[17], d[7]}, 2'b11);
    tx_take(b, vb); chk("R11 tx data", b, 8'h77); tx_busy = 0;
    for (int i = 0; i < RXD; i++) rx_put(8'(i), 0);
    chk("R11 rts low when full", rts, 0);
    rd(A_STS, d); chk("R9 rts bit", d[8], 0);

    // R10 disable flushes
    wr(A_CTL, 0);
    chk("R10 no tx valid", tx_valid, 0);
    wr(A_TXD, 8'h11); rx_put(8'h22, 0);
    rd(A_STS, d); chk("R10 flushed", {d[10], d[5], lvl_of(d)}, {2'b11, 6'd0});
    wr(A_CTL, EN | 32'h4000);
    rd(A_STS, d); chk("R10 tx write ignored", lvl_of(d), 0);

    // R12 DMA requests
    wr(A_CTL, EN | (32'h3 << 16));
    chk("R12 tx dma", dma_tx, 1); chk("R12 rx dma idle", dma_rx, 0);
    rx_put(8'h44, 0); chk("R12 rx dma", dma_rx, 1);
    rd(A_RXD, d); last_rx = 8'h44;
    chk("R12 rx dma drop", dma_rx, 0);

    // random mix of both directions
    wr(A_CTL, EN);
    for (int i = 0; i < 80; i++) begin
      case ($urandom % 4)
        0: if (txq.size() < TXD) begin b = 8'($urandom); txq.push_back(b); wr(A_TXD, b); end
        1: if (rxq.size() < RXD) begin b = 8'($urandom); rxq.push_back(b); rx_put(b, 0); end
        2: begin
          if (rxq.size() > 0) last_rx = rxq.pop_front();
          rd(A_RXD, d); chk("R5 random rx", d, {24'b0, last_rx});
        end
        default: if (txq.size() > 0) begin tx_take(b, vb); chk("R3 random tx", b, txq.pop_front()); end
      endcase
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule